// File: doc/BRIEF.md
# Windowed Address Decoder with Open-Bus Completion

This block sits between the data port of a 32-bit processor and the targets behind it: two 1 MB RAM windows (one cached and one uncached) and up to 255 components. Each component is reached through a numbered identifier, an 8-bit component number. Each component has two spaces: a small configuration window and a larger main I/O window. For every request the block sorts the address into one of four regions. It raises a one-hot select for that region and forwards the component number, the offset inside the target and the write fields. When the selected target acknowledges, the block hands the target's read data back to the processor.

Some requests are claimed by no target. These include addresses outside every window, the reserved component number 0xFF, malformed configuration offsets, and targets that stay silent for too long. Such a request neither hangs nor faults. It completes with all-ones read data, and any write it carries reaches no target. The processor issues a one-cycle request pulse while `cpu_ready` is high and then waits for the one-cycle `cpu_ack` pulse.

Top module: `vidbus_decoder`

## Requirements
- R1: After reset `cpu_ack` is 0, `tgt_sel` is 0 and `cpu_ready` is 1.
- R2: An address whose bits 31:20 equal 0x800 selects cached RAM (`tgt_sel` = 4'b0001), with offset equal to address bits 19:0 and component number 0.
- R3: An address whose bits 31:20 equal 0xA00 selects uncached RAM (`tgt_sel` = 4'b0010), with offset equal to address bits 19:0.
- R4: An address with bits 31:24 = 0xBE and bits 15:8 = 0 selects configuration space (`tgt_sel` = 4'b0100). The component number is bits 23:16 and the offset is bits 7:0, zero-extended.
- R5: An address with bits 31:24 = 0xBF selects main I/O space (`tgt_sel` = 4'b1000). The component number is bits 23:16 and the offset is bits 15:0, zero-extended.
- R6: In either component space, component number 0xFF never raises a select. The request completes as open bus.
- R7: A configuration-space address with nonzero bits 15:8 is unclaimed. It raises no select and completes as open bus.
- R8: Every unclaimed request completes with `cpu_ack` visible one cycle after acceptance and `cpu_rdata` = 0xFFFFFFFF. No select is raised, so a write is discarded.
- R9: If the selected target's `tgt_ack` bit is high at a clock edge, that edge drops the select and raises `cpu_ack`, with `cpu_rdata` taken from that region's slice of `tgt_rdata` (region k at bits 32k+31:32k).
- R10: Ack bits of regions that are not selected are ignored.
- R11: If no ack arrives during the 8 cycles the select is high, the decoder drops the select and completes the request itself with 0xFFFFFFFF.
- R12: While a select is high, `tgt_we`, `tgt_wdata` and `tgt_be` carry the accepted request's write fields, and the component number and offset stay stable.
- R13: `cpu_ack` is a one-cycle pulse, and `cpu_ready` is low from acceptance until the cycle after `cpu_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle request pulse, taken while `cpu_ready` is high |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 32 | Request address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables |
| cpu_ready | output | 1 | Decoder can accept a request |
| cpu_ack | output | 1 | Request completed (one-cycle pulse) |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| tgt_sel | output | 4 | One-hot region select: 0 cached RAM, 1 uncached RAM, 2 config, 3 main I/O |
| tgt_we | output | 1 | Forwarded write flag |
| tgt_vid | output | 8 | Component number |
| tgt_off | output | 20 | Offset inside the target |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_be | output | 4 | Forwarded byte enables |
| tgt_ack | input | 4 | Per-region completion |
| tgt_rdata | input | 128 | Per-region read data, region k at bits 32k+31:32k |

## Verification
The request is accepted at edge E0. The select fields appear after E0 and are checked at the next falling edge. An unclaimed request shows `cpu_ack` right after E0. A target that acks in its d-th selected cycle (d from 0) produces `cpu_ack` after edge E0+d+1. A silent target produces it after E0+8. Before each request, the driver stores the expected data and the exact due cycle in a queue. The monitor compares each `cpu_ack` at a falling edge with both values, so early, late or wrong-data completions are reported.

// File: rtl/vb_pkg.sv
package vb_pkg;
    localparam int NUM_RGN  = 4;
    localparam int RGN_CRAM = 0;
    localparam int RGN_URAM = 1;
    localparam int RGN_CFG  = 2;
    localparam int RGN_IO   = 3;
    localparam int VID_W    = 8;
    localparam logic [VID_W-1:0] VID_ROOT = '1;

    typedef enum logic {
        PH_IDLE,
        PH_WAIT
    } phase_e;
endpackage

// File: rtl/vb_addr_decode.sv
module vb_addr_decode
    import vb_pkg::*;
#(
    parameter int          RAM_AW    = 20,
    parameter int          OFF_W     = 20,
    parameter int          CFG_OFF_W = 8,
    parameter int          IO_OFF_W  = 16,
    parameter logic [31:0] CRAM_BASE = 32'h8000_0000,
    parameter logic [31:0] URAM_BASE = 32'hA000_0000,
    parameter logic [7:0]  CFG_TAG   = 8'hBE,
    parameter logic [7:0]  IO_TAG    = 8'hBF
) (
    input  logic [31:0]        addr,
    output logic               hit,
    output logic [NUM_RGN-1:0] sel,
    output logic [VID_W-1:0]   vid,
    output logic [OFF_W-1:0]   off
);
    logic [VID_W-1:0] addr_vid;
    logic             vid_ok;
    logic             cfg_pad_zero;

    assign addr_vid     = addr[23:16];
    assign vid_ok       = (addr_vid != VID_ROOT);
    assign cfg_pad_zero = (addr[15:CFG_OFF_W] == '0);

    always_comb begin
        sel = '0;
        vid = '0;
        off = '0;
        if (addr[31:RAM_AW] == CRAM_BASE[31:RAM_AW]) begin
            sel[RGN_CRAM] = 1'b1;
            off           = OFF_W'(addr[RAM_AW-1:0]);
        end else if (addr[31:RAM_AW] == URAM_BASE[31:RAM_AW]) begin
            sel[RGN_URAM] = 1'b1;
            off           = OFF_W'(addr[RAM_AW-1:0]);
        end else if (addr[31:24] == CFG_TAG) begin
            if (vid_ok && cfg_pad_zero) begin
                sel[RGN_CFG] = 1'b1;
                vid          = addr_vid;
                off          = OFF_W'(addr[CFG_OFF_W-1:0]);
            end
        end else if (addr[31:24] == IO_TAG) begin
            if (vid_ok) begin
                sel[RGN_IO] = 1'b1;
                vid         = addr_vid;
                off         = OFF_W'(addr[IO_OFF_W-1:0]);
            end
        end
        hit = |sel;
    end
endmodule

// File: rtl/vb_resp_mux.sv
module vb_resp_mux
    import vb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [NUM_RGN-1:0]        sel,
    input  logic [NUM_RGN-1:0]        ack,
    input  logic [NUM_RGN*DATA_W-1:0] rdata_in,
    output logic                      hit,
    output logic [DATA_W-1:0]         rdata_out
);
    logic [NUM_RGN-1:0]  taken;
    logic [DATA_W-1:0]   masked [NUM_RGN];

    for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
        assign taken[r]  = sel[r] & ack[r];
        assign masked[r] = rdata_in[r*DATA_W +: DATA_W] & {DATA_W{taken[r]}};
    end

    always_comb begin
        rdata_out = '0;
        for (int r = 0; r < NUM_RGN; r++) begin
            rdata_out = rdata_out | masked[r];
        end
    end

    assign hit = |taken;
endmodule

// File: rtl/vb_wait_timer.sv
module vb_wait_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/vidbus_decoder.sv
module vidbus_decoder
    import vb_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int RAM_AW      = 20,
    parameter int OFF_W       = 20,
    parameter int TIMEOUT_CYC = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req,
    input  logic                      cpu_we,
    input  logic [31:0]               cpu_addr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    input  logic [DATA_W/8-1:0]       cpu_be,
    output logic                      cpu_ready,
    output logic                      cpu_ack,
    output logic [DATA_W-1:0]         cpu_rdata,
    output logic [NUM_RGN-1:0]        tgt_sel,
    output logic                      tgt_we,
    output logic [VID_W-1:0]          tgt_vid,
    output logic [OFF_W-1:0]          tgt_off,
    output logic [DATA_W-1:0]         tgt_wdata,
    output logic [DATA_W/8-1:0]       tgt_be,
    input  logic [NUM_RGN-1:0]        tgt_ack,
    input  logic [NUM_RGN*DATA_W-1:0] tgt_rdata
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        phase_e               phase;
        logic [NUM_RGN-1:0]   sel;
        logic                 we;
        logic [VID_W-1:0]     vid;
        logic [OFF_W-1:0]     off;
        logic [DATA_W-1:0]    wdata;
        logic [BE_W-1:0]      be;
        logic                 ack;
        logic [DATA_W-1:0]    rdata;
    } state_t;

    state_t st_d, st_q;

    logic               dec_hit;
    logic [NUM_RGN-1:0] dec_sel;
    logic [VID_W-1:0]   dec_vid;
    logic [OFF_W-1:0]   dec_off;
    logic               mux_hit;
    logic [DATA_W-1:0]  mux_rdata;
    logic               accept;
    logic               expired;

    vb_addr_decode #(
        .RAM_AW (RAM_AW),
        .OFF_W  (OFF_W)
    ) u_decode (
        .addr (cpu_addr),
        .hit  (dec_hit),
        .sel  (dec_sel),
        .vid  (dec_vid),
        .off  (dec_off)
    );

    vb_resp_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .sel       (st_q.sel),
        .ack       (tgt_ack),
        .rdata_in  (tgt_rdata),
        .hit       (mux_hit),
        .rdata_out (mux_rdata)
    );

    vb_wait_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     (st_q.phase == PH_WAIT),
        .expired (expired)
    );

    assign cpu_ready = (st_q.phase == PH_IDLE) && !st_q.ack;
    assign accept    = cpu_req && cpu_ready;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    if (dec_hit) begin
                        st_d.phase = PH_WAIT;
                        st_d.sel   = dec_sel;
                        st_d.vid   = dec_vid;
                        st_d.off   = dec_off;
                        st_d.we    = cpu_we;
                        st_d.wdata = cpu_wdata;
                        st_d.be    = cpu_be;
                    end else begin
                        st_d.ack   = 1'b1;
                        st_d.rdata = '1;
                    end
                end
            end
            PH_WAIT: begin
                if (mux_hit) begin
                    st_d.phase = PH_IDLE;
                    st_d.sel   = '0;
                    st_d.ack   = 1'b1;
                    st_d.rdata = mux_rdata;
                end else if (expired) begin
                    st_d.phase = PH_IDLE;
                    st_d.sel   = '0;
                    st_d.ack   = 1'b1;
                    st_d.rdata = '1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.rdata <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_ack   = st_q.ack;
    assign cpu_rdata = st_q.rdata;
    assign tgt_sel   = st_q.sel;
    assign tgt_we    = st_q.we;
    assign tgt_vid   = st_q.vid;
    assign tgt_off   = st_q.off;
    assign tgt_wdata = st_q.wdata;
    assign tgt_be    = st_q.be;
endmodule

// File: rtl/vb_checks.sv
module vb_checks
    import vb_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int OFF_W       = 20,
    parameter int TIMEOUT_CYC = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cpu_ready,
    input logic                cpu_ack,
    input logic [DATA_W-1:0]   cpu_rdata,
    input logic [NUM_RGN-1:0]  tgt_sel,
    input logic [NUM_RGN-1:0]  tgt_ack,
    input logic [VID_W-1:0]    tgt_vid,
    input logic [OFF_W-1:0]    tgt_off
);
    int unsigned sel_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_run <= 0;
        end else if (|tgt_sel) begin
            sel_run <= sel_run + 1;
        end else begin
            sel_run <= 0;
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel)); // R2

    AST_NO_ROOT_VID: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel[RGN_CFG] || tgt_sel[RGN_IO]) |-> tgt_vid != VID_ROOT); // R6

    AST_CFG_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[RGN_CFG] |-> (tgt_off >> 8) == '0); // R7

    AST_OPEN_BUS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !$past(|(tgt_sel & tgt_ack))) |-> (&cpu_rdata)); // R8

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sel_run <= TIMEOUT_CYC); // R11

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tgt_sel) && $past(|tgt_sel)) |-> ($stable(tgt_vid) && $stable(tgt_off))); // R12

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack); // R13

    AST_BUSY_WHILE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (|tgt_sel) |-> !cpu_ready); // R13
endmodule

bind vidbus_decoder vb_checks #(
    .DATA_W      (DATA_W),
    .OFF_W       (OFF_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .cpu_ack   (cpu_ack),
    .cpu_rdata (cpu_rdata),
    .tgt_sel   (tgt_sel),
    .tgt_ack   (tgt_ack),
    .tgt_vid   (tgt_vid),
    .tgt_off   (tgt_off)
);

// File: tb/vidbus_decoder_test.sv
module vidbus_decoder_test;
    localparam time CLK_PERIOD = 10;
    localparam int  TMO        = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0;
    logic         cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [3:0]   cpu_be = '0;
    logic         cpu_ready, cpu_ack;
    logic [31:0]  cpu_rdata;
    logic [3:0]   tgt_sel;
    logic         tgt_we;
    logic [7:0]   tgt_vid;
    logic [19:0]  tgt_off;
    logic [31:0]  tgt_wdata;
    logic [3:0]   tgt_be;
    logic [3:0]   tgt_ack = '0;
    logic [127:0] tgt_rdata;

    vidbus_decoder uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_ready(cpu_ready), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .tgt_sel(tgt_sel), .tgt_we(tgt_we), .tgt_vid(tgt_vid), .tgt_off(tgt_off),
        .tgt_wdata(tgt_wdata), .tgt_be(tgt_be), .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // target model: acks in the resp_delay-th selected cycle, stray bits on other regions
    int          resp_delay = 0;
    logic [31:0] resp_data = '0;
    logic [3:0]  stray = '0;
    int          sel_cnt = 0;

    always_comb begin
        for (int r = 0; r < 4; r++) begin
            tgt_rdata[r*32 +: 32] = tgt_sel[r] ? resp_data : (32'hBAD0_0000 | 32'(r));
        end
    end

    always @(negedge clk) begin
        if (|tgt_sel) begin
            tgt_ack = ((sel_cnt == resp_delay) ? tgt_sel : 4'b0) | (stray & ~tgt_sel);
            sel_cnt++;
        end else begin
            tgt_ack = stray;
            sel_cnt = 0;
        end
    end

    // scoreboard
    typedef struct {
        logic [31:0] data;
        int          due;
        string       req;
    } exp_t;
    exp_t sb[$];

    always @(negedge clk) begin
        if (rst_n && cpu_ack) begin
            if (sb.size() == 0) begin
                check("R13 unexpected ack", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " data"}, 64'(cpu_rdata), 64'(e.data));
                check({e.req, " cycle"}, 64'(cyc), 64'(e.due));
            end
        end
    end

    task automatic access(input logic [31:0] addr, input bit we, input logic [31:0] wd,
                          input logic [3:0] esel, input logic [7:0] evid, input logic [19:0] eoff,
                          input int delay, input logic [31:0] rd, input string req);
        exp_t e;
        while (!cpu_ready) @(negedge clk);
        resp_delay = delay;
        resp_data  = rd;
        e.req = req;
        if (esel == 4'b0) begin
            e.data = '1; e.due = cyc + 1;
        end else if (delay < TMO) begin
            e.data = rd; e.due = cyc + 1 + delay + 1;
        end else begin
            e.data = '1; e.due = cyc + 1 + TMO;
        end
        sb.push_back(e);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_be = 4'hF;
        @(negedge clk);
        cpu_req = 1'b0;
        check({req, " sel"}, 64'(tgt_sel), 64'(esel));
        check("R13 ready low after accept", 64'(cpu_ready), 64'd0);
        if (esel != 4'b0) begin
            check({req, " vid"}, 64'(tgt_vid), 64'(evid));
            check({req, " off"}, 64'(tgt_off), 64'(eoff));
            check("R12 we", 64'(tgt_we), 64'(we));
            check("R12 wdata", 64'(tgt_wdata), 64'(wd));
        end
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
    endtask

    bit done = 1'b0;

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack", 64'(cpu_ack), 64'd0);
        check("R1 sel", 64'(tgt_sel), 64'd0);
        check("R1 ready", 64'(cpu_ready), 64'd1);

        access(32'h8001_2344, 0, 32'h0, 4'b0001, 8'h00, 20'h12344, 0, 32'hA1A1_0001, "R2 cached read");
        access(32'hA00F_FFFC, 1, 32'hCAFE_F00D, 4'b0010, 8'h00, 20'hFFFFC, 2, 32'h0000_1111, "R3 uncached write");
        access(32'h8010_0000, 0, 32'h0, 4'b0000, 8'h00, 20'h0, 0, 32'h0, "R8 outside RAM window");
        access(32'hBE12_0004, 0, 32'h0, 4'b0100, 8'h12, 20'h00004, 1, 32'h4462_6730, "R4 config read");
        access(32'hBEFE_00FF, 0, 32'h0, 4'b0100, 8'hFE, 20'h000FF, 0, 32'h1234_5678, "R4 config top vid");
        access(32'hBE12_0104, 0, 32'h0, 4'b0000, 8'h00, 20'h0, 0, 32'h0, "R7 config pad nonzero");
        access(32'hBFDB_1234, 1, 32'h0000_0041, 4'b1000, 8'hDB, 20'h01234, 0, 32'h0, "R5 io write");
        access(32'hBF00_FFFF, 0, 32'h0, 4'b1000, 8'h00, 20'h0FFFF, 3, 32'h5A5A_A5A5, "R5 io read");
        access(32'hBEFF_0000, 0, 32'h0, 4'b0000, 8'h00, 20'h0, 0, 32'h0, "R6 root vid config");
        access(32'hBFFF_0010, 1, 32'h7777_7777, 4'b0000, 8'h00, 20'h0, 0, 32'h0, "R6 root vid io write");
        access(32'h1234_5678, 1, 32'h9999_9999, 4'b0000, 8'h00, 20'h0, 0, 32'h0, "R8 unmapped write");
        access(32'hBF05_0000, 0, 32'h0, 4'b1000, 8'h05, 20'h00000, 100, 32'h0, "R11 silent target");
        access(32'h8000_0000, 0, 32'h0, 4'b0001, 8'h00, 20'h00000, TMO-1, 32'h0BAD_BEEF, "R11 ack on last cycle");
        stray = 4'b1100;
        access(32'h800A_BCD0, 0, 32'h0, 4'b0001, 8'h00, 20'hABCD0, 2, 32'h600D_DA7A, "R10 stray acks");
        stray = 4'b0001;
        access(32'hBF33_0008, 0, 32'h0, 4'b1000, 8'h33, 20'h00008, 100, 32'h0, "R10 stray during timeout");
        stray = 4'b0000;
        access(32'hA000_0010, 0, 32'h0, 4'b0010, 8'h00, 20'h00010, 0, 32'h3C3C_3C3C, "R9 back to back");

        repeat (3) @(negedge clk);
        check("R13 scoreboard drained", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule